// File: doc/BRIEF.md
# Microprogram Sequencer with Flag Branching

This block is the control unit of a horizontally microcoded datapath. It keeps a microprogram counter and an on-chip control store of wide microwords. Every microword carries fixed fields: two register selects, an ALU operation code, a RAM address, a small literal, a branch target and a sequencing code. The sequencer presents the fields of the current word to the datapath every cycle. It also takes the condition flags that the datapath reports for that word.

The next microaddress is picked from the current address plus one, the word's branch target, or the current address itself. The choice follows the word's sequencing code and the incoming zero, negative, overflow and carry flags. The control store is filled through a plain write port, normally while reset is held.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset drives `upc` to 0. In the first cycle after reset is released, the field outputs show the word stored at address 0.
- R2: The field outputs always decode the word stored at address `upc`. The bit positions are: sequencing code [47:45], target [44:37], `sel_a` [36:33], `sel_b` [32:29], `alu_op` [28:24], `ram_addr` [23:8], `literal` [7:0].
- R3: Sequencing code 0 (continue) makes the next `upc` equal to `upc`+1, whatever the flags. It wraps from 255 to 0.
- R4: Code 1 (jump) makes the next `upc` equal to the target, whatever the flags.
- R5: Code 2 (branch on zero) goes to the target when `flag_z` is 1. Otherwise it goes to `upc`+1.
- R6: Code 3 (branch on less-than) goes to the target when `flag_n` XOR `flag_v` is 1. Otherwise it goes to `upc`+1.
- R7: Code 4 (branch on carry) goes to the target when `flag_c` is 1. Otherwise it goes to `upc`+1.
- R8: Code 5 (hold) keeps `upc` and all field outputs unchanged, whatever the flags.
- R9: The unused codes 6 and 7 behave as continue.
- R10: A word written through the load port at an address is the word decoded at later fetches of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flag_z | input | 1 | Zero flag for the current word |
| flag_n | input | 1 | Negative (sign) flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| load_en | input | 1 | Write enable for the control store |
| load_addr | input | 8 | Control store write address |
| load_word | input | 48 | Microword to write |
| upc | output | 8 | Current microaddress |
| sel_a | output | 4 | First register select |
| sel_b | output | 4 | Second register select |
| alu_op | output | 5 | ALU operation code |
| ram_addr | output | 16 | RAM address field |
| literal | output | 8 | Literal field |

## Verification
A directed microprogram first walks every sequencing code with the deciding flag forced each way. For branch on less-than, it forces both the case where the sign flag alone is set and the case where sign and overflow cancel, so an XOR cannot be confused with a plain sign test. It also crosses 255 to 0, and it holds on one word with all flags set, which shows that the flags are ignored there. A second, random program then runs with random flags and random field contents, with no hold code in it. That run separates mistakes in field slicing from mistakes in next-address selection. The second program is loaded during a reset that cuts the hold short, which shows that a reset leaves the hold and that the reloaded store is what gets fetched.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    SC_NEXT = 3'd0,
    SC_JUMP = 3'd1,
    SC_BZ   = 3'd2,
    SC_BLT  = 3'd3,
    SC_BC   = 3'd4,
    SC_HOLD = 3'd5,
    SC_RSV6 = 3'd6,
    SC_RSV7 = 3'd7
  } seq_code_e;

  localparam int CODE_W = 3;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 8,
  parameter int WW = 48
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  // registered read, read-before-write on an address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int RW   = 4,
  parameter int OPW  = 5,
  parameter int MAW  = 16,
  parameter int LITW = 8,
  localparam int WW  = CODE_W + AW + 2*RW + OPW + MAW + LITW
) (
  input  logic [WW-1:0]   word,
  output seq_code_e       code,
  output logic [AW-1:0]   target,
  output logic [RW-1:0]   sel_a,
  output logic [RW-1:0]   sel_b,
  output logic [OPW-1:0]  alu_op,
  output logic [MAW-1:0]  ram_addr,
  output logic [LITW-1:0] literal
);
  localparam int LIT_LSB = 0;
  localparam int RAM_LSB = LIT_LSB + LITW;
  localparam int OP_LSB  = RAM_LSB + MAW;
  localparam int B_LSB   = OP_LSB + OPW;
  localparam int A_LSB   = B_LSB + RW;
  localparam int TGT_LSB = A_LSB + RW;
  localparam int CTL_LSB = TGT_LSB + AW;

  assign literal  = word[LIT_LSB +: LITW];
  assign ram_addr = word[RAM_LSB +: MAW];
  assign alu_op   = word[OP_LSB  +: OPW];
  assign sel_b    = word[B_LSB   +: RW];
  assign sel_a    = word[A_LSB   +: RW];
  assign target   = word[TGT_LSB +: AW];
  assign code     = seq_code_e'(word[CTL_LSB +: CODE_W]);
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = 8
) (
  input  seq_code_e     code,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] target,
  input  logic          flag_z,
  input  logic          flag_n,
  input  logic          flag_v,
  input  logic          flag_c,
  output logic [AW-1:0] nxt
);
  logic taken;
  logic [AW-1:0] inc;

  assign inc = cur + 1'b1;

  always_comb begin
    case (code)
      SC_JUMP: taken = 1'b1;
      SC_BZ:   taken = flag_z;
      SC_BLT:  taken = flag_n ^ flag_v;
      SC_BC:   taken = flag_c;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (code == SC_HOLD) nxt = cur;
    else if (taken)      nxt = target;
    else                 nxt = inc;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int RW   = 4,
  parameter int OPW  = 5,
  parameter int MAW  = 16,
  parameter int LITW = 8,
  localparam int WW  = CODE_W + AW + 2*RW + OPW + MAW + LITW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flag_z,
  input  logic            flag_n,
  input  logic            flag_v,
  input  logic            flag_c,
  input  logic            load_en,
  input  logic [AW-1:0]   load_addr,
  input  logic [WW-1:0]   load_word,
  output logic [AW-1:0]   upc,
  output logic [RW-1:0]   sel_a,
  output logic [RW-1:0]   sel_b,
  output logic [OPW-1:0]  alu_op,
  output logic [MAW-1:0]  ram_addr,
  output logic [LITW-1:0] literal
);
  logic [WW-1:0] cur_word;
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] fetch_addr;
  logic [AW-1:0] dec_tgt;
  seq_code_e     dec_code;

  // the store always fetches the address that upc takes at the same edge
  assign fetch_addr = rst ? '0 : nxt_addr;

  always_ff @(posedge clk) begin
    upc <= fetch_addr;
  end

  useq_store #(.AW(AW), .WW(WW)) u_store (
    .clk   (clk),
    .we    (load_en),
    .waddr (load_addr),
    .wdata (load_word),
    .raddr (fetch_addr),
    .rdata (cur_word)
  );

  useq_decode #(.AW(AW), .RW(RW), .OPW(OPW), .MAW(MAW), .LITW(LITW)) u_dec (
    .word     (cur_word),
    .code     (dec_code),
    .target   (dec_tgt),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .alu_op   (alu_op),
    .ram_addr (ram_addr),
    .literal  (literal)
  );

  useq_next #(.AW(AW)) u_next (
    .code   (dec_code),
    .cur    (upc),
    .target (dec_tgt),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .flag_c (flag_c),
    .nxt    (nxt_addr)
  );
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int RW  = 4,
  parameter int OPW = 5,
  parameter int MAW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     code,
  input logic [AW-1:0]  target,
  input logic [AW-1:0]  upc,
  input logic           flag_z,
  input logic           flag_n,
  input logic           flag_v,
  input logic           flag_c,
  input logic           load_en,
  input logic [RW-1:0]  sel_a,
  input logic [OPW-1:0] alu_op,
  input logic [MAW-1:0] ram_addr
);
  logic          rst_q;
  logic [AW-1:0] upc_inc;

  always_ff @(posedge clk) rst_q <= rst;
  assign upc_inc = upc + 1'b1;

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> upc == '0); // R1

  AST_CONTINUE: assert property (@(posedge clk) disable iff (rst)
    code == SC_NEXT |=> upc == $past(upc_inc)); // R3

  AST_JUMP: assert property (@(posedge clk) disable iff (rst)
    code == SC_JUMP |=> upc == $past(target)); // R4

  AST_BZ_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (code == SC_BZ && !flag_z) |=> upc == $past(upc_inc)); // R5

  AST_BLT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (code == SC_BLT && (flag_n ^ flag_v)) |=> upc == $past(target)); // R6

  AST_BC_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (code == SC_BC && flag_c) |=> upc == $past(target)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (code == SC_HOLD && !load_en) |=>
      ($stable(upc) && $stable(sel_a) && $stable(alu_op) && $stable(ram_addr))); // R8

  AST_SPARE_CODES: assert property (@(posedge clk) disable iff (rst)
    (code == SC_RSV6 || code == SC_RSV7) |=> upc == $past(upc_inc)); // R9
endmodule

bind useq_top useq_chk #(.AW(AW), .RW(RW), .OPW(OPW), .MAW(MAW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .code     (dec_code),
  .target   (dec_tgt),
  .upc      (upc),
  .flag_z   (flag_z),
  .flag_n   (flag_n),
  .flag_v   (flag_v),
  .flag_c   (flag_c),
  .load_en  (load_en),
  .sel_a    (sel_a),
  .alu_op   (alu_op),
  .ram_addr (ram_addr)
);

// File: tb/tb_useq_top.sv
module tb_useq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flag_z = 0, flag_n = 0, flag_v = 0, flag_c = 0;
  logic        load_en = 0;
  logic [7:0]  load_addr = '0;
  logic [47:0] load_word = '0;
  logic [7:0]  upc;
  logic [3:0]  sel_a, sel_b;
  logic [4:0]  alu_op;
  logic [15:0] ram_addr;
  logic [7:0]  literal;

  int checks = 0;
  int errors = 0;
  logic [47:0] img [256];
  logic [7:0]  exp_upc;

  always #10 clk = ~clk;

  useq_top dut (
    .clk(clk), .rst(rst),
    .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c),
    .load_en(load_en), .load_addr(load_addr), .load_word(load_word),
    .upc(upc), .sel_a(sel_a), .sel_b(sel_b), .alu_op(alu_op),
    .ram_addr(ram_addr), .literal(literal)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [2:0] code, input logic [7:0] tgt);
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return {code, tgt, r[36:0]};
  endfunction

  // next address from the requirements R3..R9
  function automatic logic [7:0] model_next(input logic [47:0] w, input logic [7:0] pc,
                                             input logic z, input logic n,
                                             input logic v, input logic c);
    logic [7:0] inc;
    inc = pc + 8'd1;
    case (w[47:45])
      3'd1: return w[44:37];
      3'd2: return z ? w[44:37] : inc;
      3'd3: return (n ^ v) ? w[44:37] : inc;
      3'd4: return c ? w[44:37] : inc;
      3'd5: return pc;
      default: return inc;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] code);
    case (code)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_fields(input string req);
    logic [47:0] w;
    w = img[upc];
    check(req, {44'd0, sel_a},   {44'd0, w[36:33]});
    check(req, {44'd0, sel_b},   {44'd0, w[32:29]});
    check(req, {43'd0, alu_op},  {43'd0, w[28:24]});
    check(req, {32'd0, ram_addr},{32'd0, w[23:8]});
    check(req, {40'd0, literal}, {40'd0, w[7:0]});
  endtask

  // called at a negedge; compares, applies flags, advances one cycle
  task automatic step(input logic z, input logic n, input logic v, input logic c);
    logic [7:0] nx;
    string t;
    check("R2", {40'd0, upc}, {40'd0, exp_upc});
    check_fields("R2");
    flag_z = z; flag_n = n; flag_v = v; flag_c = c;
    nx = model_next(img[exp_upc], exp_upc, z, n, v, c);
    t = tag_of(img[exp_upc][47:45]);
    @(posedge clk); @(negedge clk);
    check(t, {40'd0, upc}, {40'd0, nx});
    exp_upc = nx;
  endtask

  // R10: program load while reset is held
  task automatic load_all();
    for (int i = 0; i < 256; i++) begin
      load_en = 1'b1; load_addr = i[7:0]; load_word = img[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed program
    for (int i = 0; i < 256; i++) img[i] = mk(3'd0, 8'($urandom()));
    img[1]   = mk(3'd1, 8'd10);
    img[10]  = mk(3'd2, 8'd20);
    img[11]  = mk(3'd1, 8'd200);
    img[20]  = mk(3'd2, 8'd30);
    img[21]  = mk(3'd3, 8'd40);
    img[40]  = mk(3'd3, 8'd50);
    img[41]  = mk(3'd4, 8'd60);
    img[60]  = mk(3'd4, 8'd70);
    img[61]  = mk(3'd6, 8'd90);
    img[62]  = mk(3'd7, 8'd90);
    img[63]  = mk(3'd1, 8'd254);
    img[200] = mk(3'd5, 8'd5);

    @(negedge clk);
    load_all();
    check("R1", {40'd0, upc}, {40'd0, 8'd0});
    check_fields("R10");
    rst = 1'b0;
    exp_upc = 8'd0;

    step(1,1,1,1);   // 0 continue, flags set
    step(1,1,1,1);   // 1 jump 10
    step(1,0,0,0);   // 10 bz taken
    step(0,1,1,1);   // 20 bz not taken
    step(0,1,0,0);   // 21 blt taken (n only)
    step(0,1,1,0);   // 40 blt not taken (n,v cancel)
    step(0,0,0,1);   // 41 bc taken
    step(1,1,0,0);   // 60 bc not taken
    step(1,1,0,1);   // 61 code 6
    step(1,0,1,1);   // 62 code 7
    step(0,0,0,0);   // 63 jump 254
    step(0,0,0,0);   // 254
    step(0,0,0,0);   // 255 wraps to 0 (R3)
    step(0,0,0,0);   // 0
    step(0,0,0,0);   // 1
    step(0,0,0,0);   // 10 bz not taken -> 11
    step(0,0,0,0);   // 11 jump 200
    for (int k = 0; k < 4; k++) step(1,1,1,1); // 200 hold (R8)
    check("R8", {40'd0, upc}, {40'd0, 8'd200});

    // reset during hold, load a random program without hold
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      logic [2:0] cd;
      cd = 3'($urandom() % 7);
      if (cd >= 3'd5) cd = cd + 3'd1;
      img[i] = mk(cd, 8'($urandom()));
    end
    load_all();
    check("R1", {40'd0, upc}, {40'd0, 8'd0});
    check_fields("R10");
    rst = 1'b0;
    exp_upc = 8'd0;
    for (int k = 0; k < 400; k++) begin
      logic [3:0] f;
      f = 4'($urandom());
      step(f[0], f[1], f[2], f[3]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule